// File: doc/BRIEF.md
# Direction-Partitioned Reconfigurable Logic Cluster

The cluster is one tile of a reconfigurable fabric. It contains four function units, one for each of the directions north, east, south and west. Each unit is a three-input lookup table. Its inputs are picked by multiplexers, and its result can leave the tile either straight away or after a flip-flop. Tiles are meant to be chained so that the east output of one tile drives the east input of the next, and likewise for the other three directions. A unit may read its own direction's incoming lane without a register in the path. Every signal that crosses to another direction is taken from a unit's flip-flop. As a result, no setting of the configuration bits can close a combinational loop across tiles. Because all routing is built from multiplexers, no setting can put two drivers on one wire either.

Configuration arrives on two independent serial chains. One chain carries the lookup tables and the output modes, and the other carries the input selections. Bits shift into shadow registers while the fabric keeps running on its active settings. A single activate strobe then copies both shadows into the active registers on one clock edge. A readback shifter takes a snapshot of the four unit flip-flops and then shifts it out serially without stopping the fabric.

Top module: `dir_cluster`

## Requirements
- R1: While rst_n is low at a rising edge, every shadow, active, unit and readback register clears, so nb_out, lcfg_sout, rcfg_sout and rb_sout read 0 after reset.
- R2: When a chain's shift enable is high at an edge, the chain's shadow moves one place toward bit 0 and its serial input enters at the top bit (bit 35). The serial output always shows shadow bit 0. Shifting never changes the active configuration or nb_out.
- R3: When cfg_activate is high at an edge, both active registers take the shadow values that were present before that edge. A shift in the same cycle affects only the shadow.
- R4: The logic chain holds 9 bits per unit, with unit d (N=0, E=1, S=2, W=3) at bits 9d..9d+8. Bits 0..7 are the truth table, indexed by {in2,in1,in0}. Bit 8 set means the unit's output comes from its flip-flop; clear means it comes from the table.
- R5: The routing chain holds 9 bits per unit, at the same positions as in R4. Input k of the unit uses bits 3k..3k+2 as its select code: 0 selects constant 0, 1 the same-direction lane, 2..5 the flip-flop of unit N, E, S, W, 6 constant 1, and 7 the inverted same-direction lane.
- R6: Each unit's flip-flop loads its table result on every edge after reset, whatever its output mode.
- R7: In a given cycle, a unit's output depends on no incoming lane other than its own direction's.
- R8: After any activated configuration, including a random one, nb_out is a defined 0/1 value in every cycle.
- R9: rb_load at an edge loads the four unit flip-flops into the readback register as they were before that edge, with bit d taken from unit d. Otherwise, rb_shift moves the register toward bit 0 and fills the top with 0. rb_sout shows bit 0. A load takes priority over a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nb_in | input | 4 | Incoming lanes, bit d for direction d |
| nb_out | output | 4 | Outgoing lanes, bit d from unit d |
| lcfg_sin | input | 1 | Logic chain serial data in |
| lcfg_shift | input | 1 | Logic chain shift enable |
| lcfg_sout | output | 1 | Logic chain serial data out |
| rcfg_sin | input | 1 | Routing chain serial data in |
| rcfg_shift | input | 1 | Routing chain shift enable |
| rcfg_sout | output | 1 | Routing chain serial data out |
| cfg_activate | input | 1 | Copy both shadows to active |
| rb_load | input | 1 | Snapshot the unit flip-flops |
| rb_shift | input | 1 | Shift the snapshot out |
| rb_sout | output | 1 | Readback serial data out |

## Verification
The two collisions that matter are activate landing in the same cycle as a shift, and a readback load landing in the same cycle as the unit flip-flops changing. The bench drives cfg_activate together with the last shift of a stream, and a reference model expects the active settings to hold the pre-shift shadow. It then loads the readback while a self-toggling unit runs, and with rb_shift also high in that cycle. The snapshot it expects is the pre-edge flip-flop state, with the load winning over the shift.

// File: rtl/dcl_pkg.sv
// Shared constants for the direction-partitioned cluster.
// Assumes four directions and three-input lookup tables.
package dcl_pkg;
    localparam int NDIR     = 4;
    localparam int LUT_K    = 3;
    localparam int LUT_BITS = 1 << LUT_K;
    localparam int SEL_W    = 3;
    localparam int LCFG_W   = LUT_BITS + 1;
    localparam int RCFG_W   = LUT_K * SEL_W;

    localparam logic [SEL_W-1:0] SRC_ZERO   = 3'd0;
    localparam logic [SEL_W-1:0] SRC_SAME   = 3'd1;
    localparam logic [SEL_W-1:0] SRC_REG_N  = 3'd2;
    localparam logic [SEL_W-1:0] SRC_REG_E  = 3'd3;
    localparam logic [SEL_W-1:0] SRC_REG_S  = 3'd4;
    localparam logic [SEL_W-1:0] SRC_REG_W  = 3'd5;
    localparam logic [SEL_W-1:0] SRC_ONE    = 3'd6;
    localparam logic [SEL_W-1:0] SRC_SAME_N = 3'd7;
endpackage

// File: rtl/cfg_chain.sv
// Shadowed serial configuration chain.
// The shadow shifts toward bit 0 when shift is high. The active copy
// takes the pre-edge shadow when act is high. Assumes a synchronous
// active-low reset.
module cfg_chain #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sin,
    input  logic         shift,
    input  logic         act,
    output logic         sout,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow;

    // Shadow register: serial load, top bit first in, bit 0 first out.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (shift) shadow <= {sin, shadow[W-1:1]};
    end

    // Active register: whole-word copy on activate.
    always_ff @(posedge clk) begin
        if (!rst_n)   active <= '0;
        else if (act) active <= shadow;
    end

    assign sout = shadow[0];

    AST_ACT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> active == $past(shadow)); // R3
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> $stable(active)); // R2
    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> (shadow[W-1] == $past(sin)) && (shadow[W-2:0] == $past(shadow[W-1:1]))); // R2
endmodule

// File: rtl/func_unit.sv
// One direction's function unit: three input multiplexers, a lookup
// table, a flip-flop and an output mode select. Assumes the only
// combinational lane it sees is its own direction's; every other
// source is a registered unit output.
module func_unit
    import dcl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LCFG_W-1:0] lcfg,
    input  logic [RCFG_W-1:0] rcfg,
    input  logic              same_in,
    input  logic [NDIR-1:0]   regs,
    output logic              q,
    output logic              y
);
    logic [LUT_K-1:0] lut_idx;
    logic             lut_o;

    // Input multiplexers, one per table input.
    for (genvar k = 0; k < LUT_K; k++) begin : g_in
        logic [SEL_W-1:0] sel;
        assign sel = rcfg[k*SEL_W +: SEL_W];
        always_comb begin
            case (sel)
                SRC_ZERO:   lut_idx[k] = 1'b0;
                SRC_SAME:   lut_idx[k] = same_in;
                SRC_REG_N:  lut_idx[k] = regs[0];
                SRC_REG_E:  lut_idx[k] = regs[1];
                SRC_REG_S:  lut_idx[k] = regs[2];
                SRC_REG_W:  lut_idx[k] = regs[3];
                SRC_ONE:    lut_idx[k] = 1'b1;
                default:    lut_idx[k] = ~same_in;
            endcase
        end
    end

    // Table lookup.
    assign lut_o = lcfg[lut_idx];

    // Unit flip-flop: captures the table result every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= lut_o;
    end

    // Output mode: registered or direct.
    assign y = lcfg[LUT_BITS] ? q : lut_o;
endmodule

// File: rtl/rb_shifter.sv
// Readback snapshot register. A load captures parallel data; otherwise
// a shift moves it toward bit 0 with zero fill. Load has priority.
module rb_shifter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] pdata,
    output logic         sout
);
    logic [W-1:0] sr;

    // Snapshot and serial shift.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= pdata;
        else if (shift) sr <= {1'b0, sr[W-1:1]};
    end

    assign sout = sr[0];

    AST_RB_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> sr == $past(pdata)); // R9
    AST_RB_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && shift) |=> sr[W-1] == 1'b0); // R9
endmodule

// File: rtl/dir_cluster.sv
// Top of the cluster: two shadowed configuration chains, four
// function units and a readback shifter. Assumes tiles are chained
// lane by lane in the same direction, so the only combinational path
// is nb_in[d] to nb_out[d].
module dir_cluster
    import dcl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] nb_in,
    output logic [3:0] nb_out,
    input  logic       lcfg_sin,
    input  logic       lcfg_shift,
    output logic       lcfg_sout,
    input  logic       rcfg_sin,
    input  logic       rcfg_shift,
    output logic       rcfg_sout,
    input  logic       cfg_activate,
    input  logic       rb_load,
    input  logic       rb_shift,
    output logic       rb_sout
);
    localparam int LW = NDIR * LCFG_W;
    localparam int RW = NDIR * RCFG_W;

    logic [LW-1:0]   lcfg_act;
    logic [RW-1:0]   rcfg_act;
    logic [NDIR-1:0] unit_q;

    // Logic configuration chain.
    cfg_chain #(.W(LW)) u_lchain (
        .clk(clk), .rst_n(rst_n), .sin(lcfg_sin), .shift(lcfg_shift),
        .act(cfg_activate), .sout(lcfg_sout), .active(lcfg_act)
    );

    // Routing configuration chain.
    cfg_chain #(.W(RW)) u_rchain (
        .clk(clk), .rst_n(rst_n), .sin(rcfg_sin), .shift(rcfg_shift),
        .act(cfg_activate), .sout(rcfg_sout), .active(rcfg_act)
    );

    // One function unit per direction.
    for (genvar d = 0; d < NDIR; d++) begin : g_unit
        func_unit u_fu (
            .clk(clk), .rst_n(rst_n),
            .lcfg(lcfg_act[d*LCFG_W +: LCFG_W]),
            .rcfg(rcfg_act[d*RCFG_W +: RCFG_W]),
            .same_in(nb_in[d]), .regs(unit_q),
            .q(unit_q[d]), .y(nb_out[d])
        );
    end

    // Readback of the unit flip-flops.
    rb_shifter #(.W(NDIR)) u_rb (
        .clk(clk), .rst_n(rst_n), .load(rb_load), .shift(rb_shift),
        .pdata(unit_q), .sout(rb_sout)
    );

    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(nb_out)); // R8
    AST_SOUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({lcfg_sout, rcfg_sout, rb_sout})); // R1
endmodule

// File: tb/sim_dir_cluster.sv
`timescale 1ns/1ps
module sim_dir_cluster;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] nb_in = '0;
    logic [3:0] nb_out;
    logic lcfg_sin = 0, lcfg_shift = 0, lcfg_sout;
    logic rcfg_sin = 0, rcfg_shift = 0, rcfg_sout;
    logic cfg_activate = 0, rb_load = 0, rb_shift = 0, rb_sout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model state
    logic [35:0] m_lsh = '0, m_lact = '0, m_rsh = '0, m_ract = '0;
    logic [3:0]  m_q = '0, m_rb = '0;

    always #4 clk = ~clk;

    dir_cluster u0 (
        .clk(clk), .rst_n(rst_n), .nb_in(nb_in), .nb_out(nb_out),
        .lcfg_sin(lcfg_sin), .lcfg_shift(lcfg_shift), .lcfg_sout(lcfg_sout),
        .rcfg_sin(rcfg_sin), .rcfg_shift(rcfg_shift), .rcfg_sout(rcfg_sout),
        .cfg_activate(cfg_activate), .rb_load(rb_load), .rb_shift(rb_shift),
        .rb_sout(rb_sout)
    );

    // select code meaning per R5
    function automatic logic src_val(logic [2:0] sel, logic same, logic [3:0] q);
        case (sel)
            3'd0: return 1'b0;
            3'd1: return same;
            3'd2: return q[0];
            3'd3: return q[1];
            3'd4: return q[2];
            3'd5: return q[3];
            3'd6: return 1'b1;
            default: return ~same;
        endcase
    endfunction

    // table results per R4/R5
    function automatic logic [3:0] model_lut(logic [35:0] l, logic [35:0] r,
                                             logic [3:0] in, logic [3:0] q);
        logic [3:0] res;
        for (int d = 0; d < 4; d++) begin
            logic [2:0] idx;
            for (int k = 0; k < 3; k++)
                idx[k] = src_val(r[d*9 + k*3 +: 3], in[d], q);
            res[d] = l[d*9 + idx];
        end
        return res;
    endfunction

    // outputs per R4 mode bit
    function automatic logic [3:0] model_out(logic [35:0] l, logic [3:0] lut, logic [3:0] q);
        logic [3:0] res;
        for (int d = 0; d < 4; d++) res[d] = l[d*9 + 8] ? q[d] : lut[d];
        return res;
    endfunction

    function automatic logic [8:0] rsel(logic [2:0] s0, logic [2:0] s1, logic [2:0] s2);
        return {s2, s1, s0};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one clock: drive at negedge, check, advance the model
    task automatic step(logic [3:0] in, logic lsi, logic lsh, logic rsi, logic rsh,
                        logic act, logic rbl, logic rbs, string tag);
        logic [3:0] lut;
        @(negedge clk);
        nb_in = in; lcfg_sin = lsi; lcfg_shift = lsh; rcfg_sin = rsi; rcfg_shift = rsh;
        cfg_activate = act; rb_load = rbl; rb_shift = rbs;
        #1;
        lut = model_lut(m_lact, m_ract, in, m_q);
        chk(tag, "nb_out", 32'(nb_out), 32'(model_out(m_lact, lut, m_q)));
        chk("R2", "lcfg_sout", 32'(lcfg_sout), 32'(m_lsh[0]));
        chk("R2", "rcfg_sout", 32'(rcfg_sout), 32'(m_rsh[0]));
        chk("R9", "rb_sout", 32'(rb_sout), 32'(m_rb[0]));
        if (act) begin m_lact = m_lsh; m_ract = m_rsh; end
        if (lsh) m_lsh = {lsi, m_lsh[35:1]};
        if (rsh) m_rsh = {rsi, m_rsh[35:1]};
        if (rbl) m_rb = m_q;
        else if (rbs) m_rb = {1'b0, m_rb[3:1]};
        m_q = lut;
    endtask

    // shift both streams; optionally activate on the last shift
    task automatic load_cfg(logic [35:0] l, logic [35:0] r, bit act_on_last);
        for (int i = 0; i < 36; i++)
            step(4'($urandom), l[i], 1'b1, r[i], 1'b1,
                 act_on_last && (i == 35), 1'b0, 1'b0, act_on_last && (i == 35) ? "R3" : "R2");
        step(4'($urandom), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    endtask

    initial begin
        logic [35:0] la, ra;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        step(4'hF, 0, 0, 0, 0, 0, 0, 0, "R1");
        step(4'h5, 0, 0, 0, 0, 0, 0, 0, "R1");

        // directed config: N = AND(same, regE); E toggles, registered;
        // S = inverted same lane; W = constant one, registered
        la = '0; ra = '0;
        la[0 +: 9]  = {1'b0, 8'h88};
        la[9 +: 9]  = {1'b1, 8'h55};
        la[18 +: 9] = {1'b0, 8'hAA};
        la[27 +: 9] = {1'b1, 8'hAA};
        ra[0 +: 9]  = rsel(3'd1, 3'd3, 3'd0);
        ra[9 +: 9]  = rsel(3'd3, 3'd0, 3'd0);
        ra[18 +: 9] = rsel(3'd7, 3'd0, 3'd0);
        ra[27 +: 9] = rsel(3'd6, 3'd0, 3'd0);
        load_cfg(la, ra, 1'b0);
        for (int i = 0; i < 6; i++) step(4'(i * 5), 0, 0, 0, 0, 0, 0, 0, "R4");
        // R7: only non-own lanes move around a fixed N lane
        for (int i = 0; i < 6; i++) step({3'(i), 1'b1}, 0, 0, 0, 0, 0, 0, 0, "R7");
        // R6: registered outputs follow flip-flops
        for (int i = 0; i < 4; i++) step(4'b0100, 0, 0, 0, 0, 0, 0, 0, "R6");
        // R9: load together with shift, then shift out
        step(4'h0, 0, 0, 0, 0, 0, 1, 1, "R9");
        for (int i = 0; i < 5; i++) step(4'h0, 0, 0, 0, 0, 0, 0, 1, "R9");
        step(4'h0, 0, 0, 0, 0, 0, 1, 0, "R9");
        step(4'h0, 0, 0, 0, 0, 0, 0, 1, "R9");

        // R3: activate on the last shift takes the pre-shift shadow
        load_cfg({$urandom, $urandom}, {$urandom, $urandom}, 1'b1);
        for (int i = 0; i < 4; i++) step(4'($urandom), 0, 0, 0, 0, 0, 0, 0, "R3");

        // R5/R8: random configurations
        for (int n = 0; n < 20; n++) begin
            load_cfg({$urandom, $urandom}, {$urandom, $urandom}, 1'b0);
            for (int i = 0; i < 6; i++)
                step(4'($urandom), 0, 0, 0, 0, 0, 1'($urandom), 1'($urandom), "R8");
        end

        // R1: reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        nb_in = 4'hF; cfg_activate = 0; lcfg_shift = 0; rcfg_shift = 0; rb_load = 0; rb_shift = 0;
        @(negedge clk); rst_n = 1'b1;
        m_lsh = '0; m_lact = '0; m_rsh = '0; m_ract = '0; m_q = '0; m_rb = '0;
        step(4'hF, 0, 0, 0, 0, 0, 0, 0, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule